// File: doc/BRIEF.md
# Banked LED PWM Dimming Controller

The controller holds eight byte-wide registers, written and read over a plain address, data and write-strobe port. It drives six LED on/off outputs, grouped as three banks of two. Each bank's brightness comes from two codes: the bank's own duty code and a global dimming code that all banks share. A single 12-bit counter runs freely and is shared by every output. An LED output is high while the counter is below its bank's 12-bit duty level.

Two dimming modes are available. In linear mode the global code is subtracted from the bank code, and the result is clamped at zero. In logarithmic mode, which is active after reset, both codes are treated as counts of roughly 0.17 dB attenuation steps. The step counts are added, saturated, and looked up in a computed exponential table. The table gives fine 12-bit resolution at very low duty. A new duty level is loaded only at the counter wrap, so a PWM period is never changed while it is running. The three current-setting registers are stored and read back and have no effect on the outputs.

Top module: `ledpwm_dimmer`

## Requirements
- R1: After reset every register reads 00h, logarithmic mode is selected and all six LED outputs are low.
- R2: A write with `wr_en` high stores `wr_data` at `addr` on the clock edge. `rd_data` shows the register at `addr` combinationally. Addresses 0, 1 and 2 are the current settings of banks A, B and C. They are stored and read back only.
- R3: Address 3 controls the channels. Bits 0 through 5 enable LEDs A1, A2, B1, B2, C1 and C2 in that order. Bit 7 is the mode: 0 selects logarithmic, 1 selects linear. Bit 6 always reads 0. An LED whose enable bit is 0 stays low.
- R4: Address 4 is the global dimming code. Addresses 5, 6 and 7 are the duty codes of banks A, B and C. In linear mode the effective code is the bank code minus the global code, or 0 when the global code is greater than or equal to the bank code. The effective code e is widened to a 12-bit level as e*16 + (e >> 4).
- R5: In logarithmic mode the step count n is the global code plus (255 minus the bank code), saturated at 255. The level is round(4095 * 10^(-0.17*n/20)) for n below 255, and 0 for n = 255.
- R6: In logarithmic mode a global code of FFh turns every bank fully off, whatever the bank codes are.
- R7: A 12-bit counter starts at 0 when reset is released and steps by one each cycle, wrapping after 4095. An enabled LED is high in exactly those cycles where the counter is below its bank's active level. Both LEDs of a bank share that level.
- R8: The active level of each bank is reloaded only on the cycle the counter wraps to 0. Register writes made during a period do not change that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 3 | Register address, used for both write and read |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the register at `addr` |
| led_on | output | 6 | LED outputs: A1, A2, B1, B2, C1, C2 from bit 0 up |

## Verification
The assertions assume only that `addr` and `wr_en` are known whenever reset is released. They place no limit on when writes happen. The level checks compare the shared global code with the codes of bank A as they sit in the register file, which reflects the mode in force at that moment. The stimulus changes registers between measured periods, and also once in the middle of a period to exercise the wrap-only reload. Every expected high count and waveform is derived from the register values as they stood at the start of the period.

// File: rtl/ledpwm_pkg.sv
// Shared definitions for the banked LED PWM dimming controller.
// Assumes the duty counter is at most 31 bits wide.
package ledpwm_pkg;

    typedef enum logic {
        MODE_LOG = 1'b0,
        MODE_LIN = 1'b1
    } dim_mode_e;

    // Elaboration-time level for a given number of 0.17 dB attenuation steps.
    function automatic int log_level(input int steps, input int cnt_w, input int max_steps);
        real full;
        real v;
        if (steps >= max_steps) begin
            return 0;
        end
        full = real'((1 << cnt_w) - 1);
        v    = full * (10.0 ** (-0.0085 * real'(steps)));
        return $rtoi(v + 0.5);
    endfunction

endpackage

// File: rtl/ledpwm_regs.sv
// Register file for the dimmer.
// Address map: current settings (banks in order), channel control, global code, then duty codes.
// Channel control holds one enable per LED in the low bits and the mode in the top bit.
// Assumes CODE_W is at least NUM_LEDS + 1.
module ledpwm_regs #(
    parameter int NUM_BANKS     = 3,
    parameter int LEDS_PER_BANK = 2,
    parameter int CODE_W        = 8,
    parameter int ADDR_W        = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [CODE_W-1:0]                  wr_data,
    output logic [CODE_W-1:0]                  rd_data,
    output logic [NUM_BANKS*LEDS_PER_BANK-1:0] chan_en,
    output logic                               lin_mode,
    output logic [CODE_W-1:0]                  glob_code,
    output logic [NUM_BANKS-1:0][CODE_W-1:0]   bank_code
);
    import ledpwm_pkg::*;

    localparam int NUM_LEDS  = NUM_BANKS * LEDS_PER_BANK;
    localparam int EN_ADDR   = NUM_BANKS;
    localparam int GLOB_ADDR = NUM_BANKS + 1;
    localparam int DUTY_BASE = NUM_BANKS + 2;

    logic [NUM_BANKS-1:0][CODE_W-1:0] cur_q;
    logic [NUM_BANKS-1:0][CODE_W-1:0] code_q;
    logic [NUM_LEDS-1:0]              en_q;
    dim_mode_e                        mode_q;
    logic [CODE_W-1:0]                glob_q;

    // Register writes, with all fields cleared under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            code_q <= '0;
            en_q   <= '0;
            mode_q <= MODE_LOG;
            glob_q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (addr == ADDR_W'(b)) begin
                    cur_q[b] <= wr_data;
                end
                if (addr == ADDR_W'(DUTY_BASE + b)) begin
                    code_q[b] <= wr_data;
                end
            end
            if (addr == ADDR_W'(EN_ADDR)) begin
                en_q   <= wr_data[NUM_LEDS-1:0];
                mode_q <= wr_data[CODE_W-1] ? MODE_LIN : MODE_LOG;
            end
            if (addr == ADDR_W'(GLOB_ADDR)) begin
                glob_q <= wr_data;
            end
        end
    end

    // Read-back multiplexer; unused channel-control bits read as zero.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(b)) begin
                rd_data = cur_q[b];
            end
            if (addr == ADDR_W'(DUTY_BASE + b)) begin
                rd_data = code_q[b];
            end
        end
        if (addr == ADDR_W'(EN_ADDR)) begin
            rd_data[NUM_LEDS-1:0] = en_q;
            rd_data[CODE_W-1]     = (mode_q == MODE_LIN);
        end
        if (addr == ADDR_W'(GLOB_ADDR)) begin
            rd_data = glob_q;
        end
    end

    assign chan_en   = en_q;
    assign lin_mode  = (mode_q == MODE_LIN);
    assign glob_code = glob_q;
    assign bank_code = code_q;

endmodule

// File: rtl/ledpwm_logtab.sv
// Constant table from attenuation step count to 12-bit duty level.
// Every entry is computed at elaboration. The last index yields zero (fully off).
module ledpwm_logtab #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic [CODE_W-1:0] steps,
    output logic [CNT_W-1:0]  level
);
    import ledpwm_pkg::*;

    localparam int DEPTH = 1 << CODE_W;

    logic [CNT_W-1:0] rom [DEPTH];

    // One constant entry per step count.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = CNT_W'(log_level(g, CNT_W, DEPTH - 1));
    end

    assign level = rom[steps];

endmodule

// File: rtl/ledpwm_level.sv
// Combines one bank's duty code with the global code into a counter-width level.
// Linear mode subtracts and clamps at zero. Logarithmic mode adds step counts, saturates, and uses the table.
// Assumes CNT_W - CODE_W is no larger than CODE_W.
module ledpwm_level #(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 12
) (
    input  logic              lin_mode,
    input  logic [CODE_W-1:0] glob_code,
    input  logic [CODE_W-1:0] bank_code,
    output logic [CNT_W-1:0]  level
);
    localparam int EXT_W = CNT_W - CODE_W;

    logic [CODE_W:0]   atten_sum;
    logic [CODE_W-1:0] atten;
    logic [CNT_W-1:0]  log_level_w;
    logic [CODE_W-1:0] lin_code;
    logic [CNT_W-1:0]  lin_level;

    // Total attenuation: global steps plus (full code minus bank code), saturated.
    always_comb begin
        atten_sum = {1'b0, glob_code} + {1'b0, ~bank_code};
        atten     = atten_sum[CODE_W] ? '1 : atten_sum[CODE_W-1:0];
    end

    ledpwm_logtab #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) u_tab (
        .steps (atten),
        .level (log_level_w)
    );

    // Linear effective code, clamped at zero.
    always_comb begin
        lin_code = (bank_code > glob_code) ? (bank_code - glob_code) : '0;
    end

    if (EXT_W > 0) begin : g_widen
        assign lin_level = {lin_code, lin_code[CODE_W-1 -: EXT_W]};
    end else begin : g_narrow
        assign lin_level = lin_code[CODE_W-1 -: CNT_W];
    end

    // Mode select between the two level paths.
    always_comb begin
        level = lin_mode ? lin_level : log_level_w;
    end

endmodule

// File: rtl/ledpwm_pwm.sv
// Shared free-running counter and per-bank active levels, reloaded only at the wrap.
// Each LED is its enable ANDed with the bank compare. Assumes levels are counter-width.
module ledpwm_pwm #(
    parameter int NUM_BANKS     = 3,
    parameter int LEDS_PER_BANK = 2,
    parameter int CNT_W         = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS-1:0][CNT_W-1:0]    next_level,
    input  logic [NUM_BANKS*LEDS_PER_BANK-1:0] chan_en,
    output logic [NUM_BANKS*LEDS_PER_BANK-1:0] led_on,
    output logic [CNT_W-1:0]                   phase,
    output logic [NUM_BANKS-1:0][CNT_W-1:0]    act_level
);
    logic [CNT_W-1:0]                phase_q;
    logic [NUM_BANKS-1:0][CNT_W-1:0] act_q;

    // Free-running period counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Reload the active levels as the counter wraps to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (phase_q == '1) begin
            act_q <= next_level;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar l = 0; l < LEDS_PER_BANK; l++) begin : g_led
            assign led_on[b*LEDS_PER_BANK + l] = chan_en[b*LEDS_PER_BANK + l] & (phase_q < act_q[b]);
        end
    end

    assign phase     = phase_q;
    assign act_level = act_q;

endmodule

// File: rtl/ledpwm_dimmer.sv
// Top of the banked LED PWM dimming controller: register file, one level path per bank, shared PWM.
// Assumes a single clock domain and synchronous active-low reset.
module ledpwm_dimmer #(
    parameter  int NUM_BANKS     = 3,
    parameter  int LEDS_PER_BANK = 2,
    parameter  int CODE_W        = 8,
    parameter  int CNT_W         = 12,
    localparam int ADDR_W        = $clog2(2 * NUM_BANKS + 2),
    localparam int NUM_LEDS      = NUM_BANKS * LEDS_PER_BANK
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CODE_W-1:0]   wr_data,
    output logic [CODE_W-1:0]   rd_data,
    output logic [NUM_LEDS-1:0] led_on
);
    logic [NUM_LEDS-1:0]              chan_en;
    logic                             lin_mode;
    logic [CODE_W-1:0]                glob_code;
    logic [NUM_BANKS-1:0][CODE_W-1:0] bank_code;
    logic [NUM_BANKS-1:0][CNT_W-1:0]  next_level;
    logic [NUM_BANKS-1:0][CNT_W-1:0]  act_level;
    logic [CNT_W-1:0]                 phase;

    ledpwm_regs #(
        .NUM_BANKS     (NUM_BANKS),
        .LEDS_PER_BANK (LEDS_PER_BANK),
        .CODE_W        (CODE_W),
        .ADDR_W        (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .chan_en   (chan_en),
        .lin_mode  (lin_mode),
        .glob_code (glob_code),
        .bank_code (bank_code)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_level
        ledpwm_level #(
            .CODE_W (CODE_W),
            .CNT_W  (CNT_W)
        ) u_level (
            .lin_mode  (lin_mode),
            .glob_code (glob_code),
            .bank_code (bank_code[b]),
            .level     (next_level[b])
        );
    end

    ledpwm_pwm #(
        .NUM_BANKS     (NUM_BANKS),
        .LEDS_PER_BANK (LEDS_PER_BANK),
        .CNT_W         (CNT_W)
    ) u_pwm (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_level (next_level),
        .chan_en    (chan_en),
        .led_on     (led_on),
        .phase      (phase),
        .act_level  (act_level)
    );

endmodule

// File: rtl/ledpwm_dimmer_chk.sv
// Assertion checker for the dimmer, attached to every instance with bind.
// Level checks look at bank A. They assume the first register after channel control is the global code.
module ledpwm_dimmer_chk #(
    parameter int NUM_BANKS     = 3,
    parameter int LEDS_PER_BANK = 2,
    parameter int CODE_W        = 8,
    parameter int CNT_W         = 12,
    parameter int ADDR_W        = 3
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [ADDR_W-1:0]                  addr,
    input logic [CODE_W-1:0]                  rd_data,
    input logic [NUM_BANKS*LEDS_PER_BANK-1:0] led_on,
    input logic [NUM_BANKS*LEDS_PER_BANK-1:0] chan_en,
    input logic                               lin_mode,
    input logic [CODE_W-1:0]                  glob_code,
    input logic [NUM_BANKS-1:0][CODE_W-1:0]   bank_code,
    input logic [NUM_BANKS-1:0][CNT_W-1:0]    next_level,
    input logic [NUM_BANKS-1:0][CNT_W-1:0]    act_level,
    input logic [CNT_W-1:0]                   phase
);
    localparam int NUM_LEDS = NUM_BANKS * LEDS_PER_BANK;
    localparam int EN_ADDR  = NUM_BANKS;

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (led_on & ~chan_en) == '0); // R3

    AST_SPARE_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(EN_ADDR)) |-> (rd_data[CODE_W-2:NUM_LEDS] == '0)); // R3

    AST_LIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_mode && (glob_code >= bank_code[0])) |-> (next_level[0] == '0)); // R4

    AST_LOG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_mode && (glob_code == '0) && (bank_code[0] == '1)) |-> (next_level[0] == '1)); // R5

    AST_LOG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_mode && (glob_code == '1)) |-> (next_level == '0)); // R6

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase == $past(phase) + 1'b1)); // R7

    AST_PAIR_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en[1:0] == 2'b11) |-> (led_on[0] == led_on[1])); // R7

    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != '1) |=> $stable(act_level)); // R8

endmodule

bind ledpwm_dimmer ledpwm_dimmer_chk #(
    .NUM_BANKS     (NUM_BANKS),
    .LEDS_PER_BANK (LEDS_PER_BANK),
    .CODE_W        (CODE_W),
    .CNT_W         (CNT_W),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .rd_data    (rd_data),
    .led_on     (led_on),
    .chan_en    (chan_en),
    .lin_mode   (lin_mode),
    .glob_code  (glob_code),
    .bank_code  (bank_code),
    .next_level (next_level),
    .act_level  (act_level),
    .phase      (phase)
);

// File: tb/test_ledpwm_dimmer.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver programs registers and queues the expected period behaviour.
// The monitor measures each LED over a whole PWM period and compares.
module test_ledpwm_dimmer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    wire  [7:0] rd_data;
    wire  [5:0] led_on;

    int checks = 0;
    int errors = 0;
    int ph = 0;
    bit done = 1'b0;

    // Shadow of the programmed registers.
    logic [7:0] sh_ctl = 8'd0;
    int sh_glob = 0;
    int sh_duty[3] = '{0, 0, 0};

    typedef struct packed {
        logic [2:0][12:0] lev;
        logic [5:0]       en;
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];
    int    hi_cnt[6];
    int    shape_err = 0;

    always #2.5 clk = ~clk;

    ledpwm_dimmer i_ledpwm_dimmer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .led_on  (led_on)
    );

    // Expected counter phase, following R7.
    always @(posedge clk) begin
        if (!rst_n) ph <= 0;
        else        ph <= (ph + 1) % 4096;
    end

    function automatic int log_model(int n);
        if (n >= 255) return 0;
        return $rtoi(4095.0 * $pow(10.0, -0.17 * n / 20.0) + 0.5);
    endfunction

    function automatic int level_model(bit lin, int g, int b);
        int e;
        int n;
        if (lin) begin
            e = (b > g) ? b - g : 0;
            return e * 16 + e / 16;
        end
        n = g + (255 - b);
        if (n > 255) n = 255;
        return log_model(n);
    endfunction

    task automatic check(bit ok, string req, int act, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en   = 1'b1;
        addr    = 3'(a);
        wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 3) sh_ctl = 8'(d);
        if (a == 4) sh_glob = d;
        if (a >= 5) sh_duty[a-5] = d;
    endtask

    task automatic rd_check(int a, int exp_v, string req);
        @(negedge clk);
        addr = 3'(a);
        #1;
        check(rd_data == 8'(exp_v), req, rd_data, exp_v);
    endtask

    function automatic exp_t build_exp();
        exp_t e;
        for (int b = 0; b < 3; b++) begin
            e.lev[b] = 13'(level_model(sh_ctl[7], sh_glob, sh_duty[b]));
        end
        e.en = sh_ctl[5:0];
        return e;
    endfunction

    // Driver: queue the expectation for the next full period. Optionally write the global code mid-period.
    task automatic expect_period(string tag, bit mid_write, int mid_glob);
        do @(negedge clk); while (ph != 0);
        sb_q.push_back(build_exp());
        tag_q.push_back(tag);
        if (mid_write) begin
            do @(negedge clk); while (ph != 2000);
            wr(4, mid_glob);
        end
        do @(negedge clk); while (ph != 4095);
        @(negedge clk);
    endtask

    // Monitor: per-cycle waveform comparison and per-period high counts.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (ph == 0) begin
                foreach (hi_cnt[i]) hi_cnt[i] = 0;
                shape_err = 0;
            end
            for (int i = 0; i < 6; i++) begin
                if (led_on[i]) hi_cnt[i]++;
                if (sb_q.size() > 0) begin
                    if (led_on[i] != (sb_q[0].en[i] && (ph < int'(sb_q[0].lev[i/2]))))
                        shape_err++;
                end
            end
            if (ph == 4095 && sb_q.size() > 0) begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                for (int i = 0; i < 6; i++) begin
                    int want;
                    want = e.en[i] ? int'(e.lev[i/2]) : 0;
                    check(hi_cnt[i] == want, $sformatf("%s led%0d high count", t, i), hi_cnt[i], want);
                end
                check(shape_err == 0, $sformatf("R7 %s waveform mismatches", t), shape_err, 0);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        for (int a = 0; a < 8; a++) rd_check(a, 0, "R1 reset readback");
        repeat (50) begin
            @(negedge clk);
            #1;
            if (led_on != 6'd0) break;
        end
        check(led_on == 6'd0, "R1 outputs low after reset", led_on, 0);

        // R2: current-setting registers stored and read back.
        wr(0, 8'h11); wr(1, 8'h5A); wr(2, 8'hC3);
        rd_check(0, 8'h11, "R2 bank A current");
        rd_check(1, 8'h5A, "R2 bank B current");
        rd_check(2, 8'hC3, "R2 bank C current");

        // R3: bit 6 of channel control reads zero.
        wr(3, 8'hFF);
        rd_check(3, 8'hBF, "R3 spare bit");

        // R4: linear subtraction, clamp, full code.
        wr(3, 8'hBF); wr(4, 8'h10); wr(5, 8'h80); wr(6, 8'h05); wr(7, 8'hFF);
        rd_check(4, 8'h10, "R2 global readback");
        rd_check(7, 8'hFF, "R2 bank C duty readback");
        expect_period("R4 linear", 1'b0, 0);

        // R3: partial enables gate individual LEDs.
        wr(3, 8'h85);
        expect_period("R3 partial enable", 1'b0, 0);

        // R5: log mode, no global dimming.
        wr(3, 8'h3F); wr(4, 8'h00); wr(5, 8'hFF); wr(6, 8'hDC); wr(7, 8'h00);
        expect_period("R5 log bank steps", 1'b0, 0);

        // R5: log mode, global plus bank steps with saturation.
        wr(4, 8'h23); wr(6, 8'h80); wr(7, 8'h10);
        expect_period("R5 log summed steps", 1'b0, 0);

        // R6: global FFh in log mode turns everything off.
        wr(4, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
        expect_period("R6 global off", 1'b0, 0);

        // R8: a mid-period change takes effect only at the next wrap.
        wr(4, 8'h00); wr(6, 8'hC0);
        expect_period("R8 unchanged period", 1'b1, 8'h40);
        expect_period("R8 next period", 1'b0, 0);

        done = 1'b1;
        finish_run();
    end

endmodule